// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block supplies the digital sequencing for a 10-bit charge-redistribution analog-to-digital converter. A queue controller first routes the desired input to the analog multiplexer. It then pulses a start strobe along with a 7-bit channel tag and a 2-bit sample-time code. The controller holds the sample capacitor in the sampling phase for the selected number of clocks. It then drives a DAC trial code, resolving one bit per clock from the most significant bit downward. A single comparator bit reports whether each trial level lies above the held input.

When the tenth bit has been decided, the full word and the channel tag appear on registered outputs, and a one-cycle end-of-conversion pulse tells the queue controller to store the result. A stop input powers down the analog section. It also aborts any conversion in progress and blocks new ones while it stays high.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `eoc`, `sample_en` are 0 and `dac_code` and `result` are 0.
- R2: A conversion starts only when `start` is high at a clock edge while idle and `stop` is low. `sample_en` and `busy` are high in the cycle after that edge. Without a start, `busy` stays 0.
- R3: The sampling phase lasts 2, 4, 8 or 16 cycles for `samp_sel` codes 0, 1, 2, 3. The code is captured at the start edge.
- R4: Approximation resolves bits from bit 9 down to bit 0, one bit per clock. In the first approximation cycle `dac_code` is 0x200. In the next cycle, bit 8 is set as the new trial.
- R5: `cmp_hi` = 1 means the trial level is above the input. On that value the current trial bit is cleared; otherwise it is kept. With an ideal comparator (`cmp_hi = dac_code > vin`), `result` equals `vin`.
- R6: `eoc` is high for exactly one cycle, N+10 cycles after the start edge, where N is the sample length. `result` is valid in that cycle and holds until the next completion.
- R7: While `stop` is high, any conversion aborts with no `eoc`, `busy` falls, `dac_code` returns to 0, `pwr_en` goes low, and starts are ignored.
- R8: A `start` pulse during a conversion is ignored. It changes neither the timing, the result nor the channel tag.
- R9: `chan_in` is captured at the start edge and presented on `chan_out` with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Power-down / abort |
| start | input | 1 | Start-conversion strobe |
| chan_in | input | 7 | Channel tag for this conversion |
| samp_sel | input | 2 | Sample-time code (2/4/8/16 cycles) |
| cmp_hi | input | 1 | Comparator: trial level above input |
| pwr_en | output | 1 | Analog bias enable (registered, inverse of stop) |
| sample_en | output | 1 | Sample switch closed |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 10 | DAC trial code |
| eoc | output | 1 | End-of-conversion pulse |
| result | output | 10 | Converted value |
| chan_out | output | 7 | Channel tag of the result |

## Verification
A wrong bit pointer or a wrong trial update shows up as a wrong `result` for some input level, and `dac_code` shows the first divergence in the cycle it happens. A wrong sample counter shifts the `eoc` cycle and the length of `sample_en`, and the bench measures both to the cycle for every sample code. State left behind after a stop or an ignored start would show up as a stray `eoc` or a changed tag within the following conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} sar_state_t;
endpackage

// File: rtl/sar_samp_timer.sv
module sar_samp_timer #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int MAX_LEN = 2 << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   len;

  assign len  = (CNT_W+1)'(2) << sel;
  assign done = run && ({1'b0, cnt} == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> ({1'b0, cnt} < len));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         step,
  input  logic         cmp_hi,
  output logic [W-1:0] code,
  output logic [W-1:0] code_nx,
  output logic         last
);
  localparam int PW = $clog2(W);

  logic [PW-1:0] ptr;

  assign last = (ptr == '0);

  always_comb begin
    code_nx = code;
    for (int i = 0; i < W; i++) begin
      if (PW'(i) == ptr) code_nx[i] = !cmp_hi;
      if (PW'(i + 1) == ptr && ptr != '0) code_nx[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
      ptr  <= '0;
    end else if (load) begin
      code <= W'(1) << (W - 1);
      ptr  <= PW'(W - 1);
    end else if (step) begin
      code <= code_nx;
      ptr  <= ptr - 1'b1;
    end
  end

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
    load && !clr |=> (code == (W'(1) << (W - 1))));
  assert_ptr_down_R4: assert property (@(posedge clk) disable iff (rst)
    step && !clr && !load && !last |=> (ptr == $past(ptr) - 1'b1));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 7,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop,
  input  logic              start,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [SEL_W-1:0]  samp_sel,
  input  logic              cmp_hi,
  output logic              pwr_en,
  output logic              sample_en,
  output logic              busy,
  output logic [RES_W-1:0]  dac_code,
  output logic              eoc,
  output logic [RES_W-1:0]  result,
  output logic [CHAN_W-1:0] chan_out
);
  import sar_pkg::*;

  sar_state_t         state;
  logic [SEL_W-1:0]   sel_q;
  logic               samp_done;
  logic               last;
  logic [RES_W-1:0]   code_nx;
  logic               load, step, clr;

  assign sample_en = (state == ST_SAMPLE);
  assign busy      = (state != ST_IDLE);
  assign load      = samp_done && !stop;
  assign step      = (state == ST_CONV) && !stop;
  assign clr       = stop || (state == ST_CONV && last) || (state == ST_IDLE);

  sar_samp_timer #(.SEL_W(SEL_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_SAMPLE),
    .sel  (sel_q),
    .done (samp_done)
  );

  sar_approx #(.W(RES_W)) u_approx (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .load    (load),
    .step    (step),
    .cmp_hi  (cmp_hi),
    .code    (dac_code),
    .code_nx (code_nx),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      eoc      <= 1'b0;
      result   <= '0;
      chan_out <= '0;
      pwr_en   <= 1'b0;
    end else begin
      eoc    <= 1'b0;
      pwr_en <= !stop;
      if (stop) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            state    <= ST_SAMPLE;
            sel_q    <= samp_sel;
            chan_out <= chan_in;
          end
          ST_SAMPLE: if (samp_done) state <= ST_CONV;
          ST_CONV: if (last) begin
            state  <= ST_IDLE;
            eoc    <= 1'b1;
            result <= code_nx;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_eoc_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);
  assert_eoc_idle_R6: assert property (@(posedge clk) disable iff (rst)
    eoc |-> !busy);
  assert_stop_abort_R7: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy && !eoc && !pwr_en));
  assert_chan_hold_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(chan_out));
  assert_start_only_R2: assert property (@(posedge clk) disable iff (rst)
    !busy && !(start && !stop) |=> !busy);
endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop = 1'b0;
  logic       start = 1'b0;
  logic [6:0] chan_in = '0;
  logic [1:0] samp_sel = '0;
  logic [9:0] vin = '0;
  logic       cmp_hi;
  logic       pwr_en, sample_en, busy, eoc;
  logic [9:0] dac_code, result;
  logic [6:0] chan_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  assign cmp_hi = (dac_code > vin);

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .stop(stop), .start(start), .chan_in(chan_in),
    .samp_sel(samp_sel), .cmp_hi(cmp_hi), .pwr_en(pwr_en),
    .sample_en(sample_en), .busy(busy), .dac_code(dac_code), .eoc(eoc),
    .result(result), .chan_out(chan_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 eoc", eoc, 0);
    chk("R1 sample_en", sample_en, 0);
    chk("R1 dac_code", dac_code, 0);
    chk("R1 result", result, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle;
    int seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || eoc) seen++;
    end
    chk("R2 no start stays idle", seen, 0);
    chk("R7 pwr_en high without stop", pwr_en, 1);
  endtask

  task automatic t_conv(input logic [9:0] v, input logic [1:0] sel,
                        input logic [6:0] ch, input bit poke);
    int n = 0, slen = 0, eoc_n = -1, eoc_cnt = 0, len;
    len = 2 << sel;
    vin = v;
    @(negedge clk);
    chan_in = ch; samp_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chan_in = ~ch; samp_sel = ~sel;
    chk("R2 sample_en after start", sample_en, 1);
    chk("R2 busy after start", busy, 1);
    while (n < len + 14) begin
      if (sample_en) slen++;
      if (n == len) chk("R4 first trial is MSB", dac_code, 10'h200);
      if (n == len + 1)
        chk("R4 second trial", dac_code, {(v >= 10'd512), 1'b1, 8'h00});
      if (poke && n == len + 3) start = 1'b1;
      if (poke && n == len + 4) start = 1'b0;
      if (eoc) begin
        eoc_cnt++;
        if (eoc_n < 0) eoc_n = n;
        chk("R5 result", result, v);
        chk("R9 chan_out", chan_out, ch);
      end
      @(negedge clk);
      n++;
    end
    chk("R3 sample length", slen, len);
    chk(poke ? "R8 eoc timing with stray start" : "R6 eoc cycle", eoc_n, len + 10);
    chk("R6 single eoc", eoc_cnt, 1);
    chk("R6 result held", result, v);
    chk(poke ? "R8 stray start ignored" : "R6 idle after eoc", busy, 0);
  endtask

  task automatic t_stop;
    int seen = 0;
    vin = 10'd300;
    @(negedge clk);
    chan_in = 7'h11; samp_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    chk("R7 busy cleared", busy, 0);
    chk("R7 dac_code cleared", dac_code, 0);
    chk("R7 pwr_en low", pwr_en, 0);
    start = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || eoc) seen++;
    end
    start = 1'b0;
    stop = 1'b0;
    chk("R7 no activity during stop", seen, 0);
    chk("R7 result untouched", result, 10'd700);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_conv(10'd0, 2'd0, 7'h05, 1'b0);
    t_conv(10'd1023, 2'd1, 7'h7F, 1'b0);
    t_conv(10'd512, 2'd2, 7'h2A, 1'b0);
    t_conv(10'd511, 2'd3, 7'h01, 1'b0);
    t_conv(10'd700, 2'd1, 7'h40, 1'b1);
    t_stop();
    t_conv(10'd341, 2'd0, 7'h33, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule